// File: doc/BRIEF.md
# Speed Command Curve Mapper

This block turns a speed command in the range 0 to 512 (512 standing for 100 %) into the value that the motor control loop should aim for. In closed-loop mode that value is a target speed in RPM. In open-loop mode it is a target output duty in 1/512 steps. The command arrives with a one-cycle sample strobe. On each strobe the block places the command in one of four bands: at or below the stop level, between the stop and start levels, on the curve above the start level, and above the clamp level. It then works out the target and registers it.

Along the curve the target is a base value plus a piecewise-linear term with one optional knee. Above the clamp the curve is held at its clamp value. When the clamp override flag is set, the block instead passes the command straight through as a direct duty and raises an override flag. It returns to the curve only after the command drops a programmable margin below the clamp. In the low bands two flags choose the target: keep running at the startup level, or run at the ceiling value when the command is zero.

A three-state controller holds the band history. ST_OFF means the output is disabled and was last reached from below. ST_RUN means the block is following the curve or the startup level. ST_DIRECT means the command is being passed through as direct duty. The transitions are:
- T_ENGAGE (ST_OFF to ST_RUN): the command rises above the start level.
- T_ENGAGE_DIRECT (ST_OFF to ST_DIRECT): the command is also above the clamp while the override flag is set.
- T_OVERRIDE (ST_RUN to ST_DIRECT): the command exceeds the clamp while the override flag is set.
- T_RETURN (ST_DIRECT to ST_RUN): the command falls below the return level, or the override flag is cleared.
- T_STOP (ST_RUN or ST_DIRECT to ST_OFF): the command is at or below the stop level.

The multiply is registered once, so results appear two clock edges after the strobe.

Top module: `speed_curve_map`

## Requirements
- R1: After reset, tgt_value is 0, tgt_en is 0 and tgt_ovr is 0.
- R2: The outputs change only on the second rising edge after an edge that samples cmd_valid high. With no strobe, they hold their values whatever cmd_value and the configuration do.
- R3: The start level is cfg_start. The stop level is 2×cfg_stop. A command above the start level enables the output (tgt_en=1). In ST_OFF, a command at or below the start level leaves the state unchanged. A command at or below the stop level takes the block to ST_OFF; with cfg_no_stop=0 and cfg_max_off=0 this gives tgt_en=0 and tgt_value=0.
- R4: On the curve in closed-loop mode, tgt_value = cfg_base + floor(cfg_slope_lo×(c−cfg_start)/64), where c is the command limited to the clamp level.
- R5: The knee level is 2×cfg_knee. When cfg_knee≠0 and c is above the knee, tgt_value = cfg_base + floor((cfg_slope_lo×(knee−start) + cfg_slope_hi×(c−knee))/64). cfg_knee=0 gives a single slope.
- R6: The clamp level is 257+cfg_clamp. With cfg_max_open=0, a command above the clamp gives the curve value at the clamp level.
- R7: With cfg_max_open=1, a command above the clamp enters ST_DIRECT. There tgt_value equals the command and tgt_ovr=1. The block returns to the curve (tgt_ovr=0) when the command falls strictly below clamp−2×(cfg_ret_hys+1).
- R8: For a command strictly between the stop and start levels, with cfg_no_stop=0, the target is 0 (tgt_en=0) in ST_OFF and cfg_base (tgt_en=1) in ST_RUN.
- R9: cfg_no_stop=1 gives the startup value (tgt_en=1) for every command at or below the start level. The one exception: with cfg_max_off also set, a command at or below the stop level gives the maximum. cfg_max_off=1 alone gives the maximum for a command of exactly 0. The maximum is cfg_ceiling with tgt_en=1.
- R10: With cfg_max_open=1, every case of R9 that gives the maximum gives instead tgt_value=512 with tgt_ovr=1.
- R11: With cfg_open_loop=1, the startup value is cfg_base[11:4] and the curve term is divided by 1024 instead of 64.
- R12: Curve and startup targets are limited to cfg_ceiling; whenever tgt_ovr=0 after an update, tgt_value ≤ cfg_ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Sample strobe for cmd_value |
| cmd_value | input | 10 | Speed command, 0 to 512 |
| cfg_start | input | 8 | Start level |
| cfg_stop | input | 7 | Stop level divided by 2 |
| cfg_clamp | input | 8 | Clamp level minus 257 |
| cfg_ret_hys | input | 4 | Return margin code, margin = 2×(code+1) |
| cfg_base | input | 12 | Startup speed; upper 8 bits give the open-loop startup duty |
| cfg_slope_lo | input | 14 | Slope below the knee |
| cfg_slope_hi | input | 14 | Slope above the knee |
| cfg_knee | input | 8 | Knee level divided by 2, 0 disables |
| cfg_ceiling | input | 16 | Maximum target |
| cfg_open_loop | input | 1 | 1 selects open-loop duty scaling |
| cfg_max_open | input | 1 | Enables direct duty above the clamp |
| cfg_no_stop | input | 1 | Keep running in the low bands |
| cfg_max_off | input | 1 | Run at the maximum when the command is zero |
| tgt_value | output | 16 | Target speed or duty |
| tgt_en | output | 1 | Output enable |
| tgt_ovr | output | 1 | Direct-duty override active |

## Verification
On every cycle the assertions check four things. A command above the start level always yields an enabled output two edges later. A command at the stop level or below, with both low-band flags clear, always yields a disabled output. The override flag never appears without the enable flag, and with it the target is either the sampled command or full scale. A non-override target never exceeds the ceiling, and the outputs never move without a strobe. Several behaviours depend on history or on exact arithmetic, and only the bench's scenarios show them. These are the rising versus falling result between the stop and start levels, the return margin out of direct duty, the knee arithmetic with its rounding down, the flag rows of the low bands and the open-loop scaling.

// File: rtl/curve_map_pkg.sv
package curve_map_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_DIRECT = 2'd2
    } band_state_t;

    typedef enum logic [2:0] {
        K_ZERO    = 3'd0,
        K_STARTUP = 3'd1,
        K_CURVE   = 3'd2,
        K_CEIL    = 3'd3,
        K_FULL    = 3'd4,
        K_FOLLOW  = 3'd5
    } tgt_kind_t;

endpackage

// File: rtl/curve_band_fsm.sv
module curve_band_fsm
    import curve_map_pkg::*;
#(
    parameter int CMD_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [CMD_W-1:0] cmd,
    input  logic [CMD_W-1:0] start_lvl,
    input  logic [CMD_W-1:0] stop_lvl,
    input  logic [CMD_W-1:0] clamp_lvl,
    input  logic [CMD_W-1:0] return_lvl,
    input  logic             max_open,
    input  logic             no_stop,
    input  logic             max_off,
    output tgt_kind_t        kind_nxt
);

    band_state_t state, nxt;

    logic above_start, at_stop, above_clamp, below_return, cmd_zero;
    tgt_kind_t top_kind;

    assign above_start  = cmd > start_lvl;
    assign at_stop      = cmd <= stop_lvl;
    assign above_clamp  = cmd > clamp_lvl;
    assign below_return = cmd < return_lvl;
    assign cmd_zero     = cmd == '0;
    assign top_kind     = max_open ? K_FULL : K_CEIL;

    // state register, advanced only on a sample strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else if (sample)
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (above_start)
                    nxt = (max_open && above_clamp) ? ST_DIRECT : ST_RUN;  // T_ENGAGE(_DIRECT)
            end
            ST_RUN: begin
                if (at_stop)
                    nxt = ST_OFF;                                         // T_STOP
                else if (max_open && above_clamp)
                    nxt = ST_DIRECT;                                      // T_OVERRIDE
            end
            ST_DIRECT: begin
                if (at_stop)
                    nxt = ST_OFF;                                         // T_STOP
                else if (!max_open || below_return)
                    nxt = ST_RUN;                                         // T_RETURN
            end
            default: nxt = ST_OFF;
        endcase
    end

    // output decision for the sample being taken
    always_comb begin
        kind_nxt = K_ZERO;
        unique case (nxt)
            ST_DIRECT: kind_nxt = K_FOLLOW;
            ST_OFF, ST_RUN: begin
                if (above_start)
                    kind_nxt = K_CURVE;
                else if (cmd_zero && max_off)
                    kind_nxt = top_kind;
                else if (at_stop)
                    kind_nxt = no_stop ? (max_off ? top_kind : K_STARTUP) : K_ZERO;
                else
                    kind_nxt = (no_stop || nxt == ST_RUN) ? K_STARTUP : K_ZERO;
            end
            default: kind_nxt = K_ZERO;
        endcase
    end

endmodule

// File: rtl/curve_arith.sv
module curve_arith
    import curve_map_pkg::*;
#(
    parameter int CMD_W    = 10,
    parameter int SLOPE_W  = 14,
    parameter int BASE_W   = 12,
    parameter int THR_W    = 8,
    parameter int TGT_W    = 16,
    parameter int CL_SHIFT = 6,
    parameter int OL_SHIFT = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample,
    input  tgt_kind_t          kind_in,
    input  logic [CMD_W-1:0]   cmd,
    input  logic [CMD_W-1:0]   start_lvl,
    input  logic [CMD_W-1:0]   knee_lvl,
    input  logic [CMD_W-1:0]   clamp_lvl,
    input  logic [SLOPE_W-1:0] slope_lo,
    input  logic [SLOPE_W-1:0] slope_hi,
    input  logic [BASE_W-1:0]  base,
    input  logic               open_loop,
    input  logic [TGT_W-1:0]   ceiling,
    output logic               p1_valid,
    output logic [TGT_W-1:0]   tgt_value,
    output logic               tgt_en,
    output logic               tgt_ovr
);

    localparam int PROD_W     = SLOPE_W + CMD_W;
    localparam int VAL_W      = PROD_W + 2;
    localparam int DUTY_SHIFT = BASE_W - THR_W;
    localparam int FULL_SCALE = 1 << (CMD_W - 1);

    // stage 1: segment lengths and products
    logic [CMD_W-1:0]  c_lim, d_lo, d_hi;
    logic [BASE_W-1:0] base_sel;
    logic [PROD_W-1:0] prod_lo_c, prod_hi_c;

    always_comb begin
        c_lim = (cmd > clamp_lvl) ? clamp_lvl : cmd;
        d_lo  = '0;
        d_hi  = '0;
        if (c_lim > start_lvl) begin
            if (knee_lvl != '0 && c_lim > knee_lvl) begin
                d_lo = knee_lvl - start_lvl;
                d_hi = c_lim - knee_lvl;
            end else begin
                d_lo = c_lim - start_lvl;
            end
        end
        base_sel  = open_loop ? (base >> DUTY_SHIFT) : base;
        prod_lo_c = PROD_W'(slope_lo) * PROD_W'(d_lo);
        prod_hi_c = PROD_W'(slope_hi) * PROD_W'(d_hi);
    end

    tgt_kind_t         kind_r;
    logic [PROD_W-1:0] prod_lo_r, prod_hi_r;
    logic [BASE_W-1:0] base_r;
    logic [CMD_W-1:0]  cmd_r;
    logic              ol_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1_valid  <= 1'b0;
            kind_r    <= K_ZERO;
            prod_lo_r <= '0;
            prod_hi_r <= '0;
            base_r    <= '0;
            cmd_r     <= '0;
            ol_r      <= 1'b0;
        end else begin
            p1_valid <= sample;
            if (sample) begin
                kind_r    <= kind_in;
                prod_lo_r <= prod_lo_c;
                prod_hi_r <= prod_hi_c;
                base_r    <= base_sel;
                cmd_r     <= cmd;
                ol_r      <= open_loop;
            end
        end
    end

    // stage 2: scale, add, saturate, select
    function automatic logic [TGT_W-1:0] sat(input logic [VAL_W-1:0] v,
                                             input logic [TGT_W-1:0] lim);
        if (v > VAL_W'(lim))
            return lim;
        return v[TGT_W-1:0];
    endfunction

    logic [VAL_W-1:0] sum_w, scaled_w, curve_w;
    logic [TGT_W-1:0] next_value;

    always_comb begin
        sum_w    = VAL_W'(prod_lo_r) + VAL_W'(prod_hi_r);
        scaled_w = ol_r ? (sum_w >> OL_SHIFT) : (sum_w >> CL_SHIFT);
        curve_w  = VAL_W'(base_r) + scaled_w;
        next_value = '0;
        unique case (kind_r)
            K_ZERO:    next_value = '0;
            K_STARTUP: next_value = sat(VAL_W'(base_r), ceiling);
            K_CURVE:   next_value = sat(curve_w, ceiling);
            K_CEIL:    next_value = ceiling;
            K_FULL:    next_value = TGT_W'(FULL_SCALE);
            K_FOLLOW:  next_value = TGT_W'(cmd_r);
            default:   next_value = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_value <= '0;
            tgt_en    <= 1'b0;
            tgt_ovr   <= 1'b0;
        end else if (p1_valid) begin
            tgt_value <= next_value;
            tgt_en    <= kind_r != K_ZERO;
            tgt_ovr   <= (kind_r == K_FULL) || (kind_r == K_FOLLOW);
        end
    end

endmodule

// File: rtl/speed_curve_map.sv
module speed_curve_map
    import curve_map_pkg::*;
#(
    parameter int CMD_W    = 10,
    parameter int THR_W    = 8,
    parameter int HYS_W    = 4,
    parameter int BASE_W   = 12,
    parameter int SLOPE_W  = 14,
    parameter int TGT_W    = 16,
    parameter int CL_SHIFT = 6,
    parameter int OL_SHIFT = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [CMD_W-1:0]   cmd_value,
    input  logic [THR_W-1:0]   cfg_start,
    input  logic [THR_W-2:0]   cfg_stop,
    input  logic [THR_W-1:0]   cfg_clamp,
    input  logic [HYS_W-1:0]   cfg_ret_hys,
    input  logic [BASE_W-1:0]  cfg_base,
    input  logic [SLOPE_W-1:0] cfg_slope_lo,
    input  logic [SLOPE_W-1:0] cfg_slope_hi,
    input  logic [THR_W-1:0]   cfg_knee,
    input  logic [TGT_W-1:0]   cfg_ceiling,
    input  logic               cfg_open_loop,
    input  logic               cfg_max_open,
    input  logic               cfg_no_stop,
    input  logic               cfg_max_off,
    output logic [TGT_W-1:0]   tgt_value,
    output logic               tgt_en,
    output logic               tgt_ovr
);

    localparam int CLAMP_OFS = (1 << (CMD_W - 2)) + 1;

    logic [CMD_W-1:0] start_lvl, stop_lvl, clamp_lvl, return_lvl, knee_lvl;
    tgt_kind_t        kind_nxt;
    logic             p1_valid;

    assign start_lvl  = CMD_W'(cfg_start);
    assign stop_lvl   = CMD_W'({cfg_stop, 1'b0});
    assign clamp_lvl  = CMD_W'(CLAMP_OFS) + CMD_W'(cfg_clamp);
    assign return_lvl = clamp_lvl - ((CMD_W'(cfg_ret_hys) + CMD_W'(1)) << 1);
    assign knee_lvl   = CMD_W'({cfg_knee, 1'b0});

    curve_band_fsm #(.CMD_W(CMD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (cmd_valid),
        .cmd        (cmd_value),
        .start_lvl  (start_lvl),
        .stop_lvl   (stop_lvl),
        .clamp_lvl  (clamp_lvl),
        .return_lvl (return_lvl),
        .max_open   (cfg_max_open),
        .no_stop    (cfg_no_stop),
        .max_off    (cfg_max_off),
        .kind_nxt   (kind_nxt)
    );

    curve_arith #(
        .CMD_W    (CMD_W),
        .SLOPE_W  (SLOPE_W),
        .BASE_W   (BASE_W),
        .THR_W    (THR_W),
        .TGT_W    (TGT_W),
        .CL_SHIFT (CL_SHIFT),
        .OL_SHIFT (OL_SHIFT)
    ) u_arith (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (cmd_valid),
        .kind_in   (kind_nxt),
        .cmd       (cmd_value),
        .start_lvl (start_lvl),
        .knee_lvl  (knee_lvl),
        .clamp_lvl (clamp_lvl),
        .slope_lo  (cfg_slope_lo),
        .slope_hi  (cfg_slope_hi),
        .base      (cfg_base),
        .open_loop (cfg_open_loop),
        .ceiling   (cfg_ceiling),
        .p1_valid  (p1_valid),
        .tgt_value (tgt_value),
        .tgt_en    (tgt_en),
        .tgt_ovr   (tgt_ovr)
    );

endmodule

// File: rtl/speed_curve_map_chk.sv
module speed_curve_map_chk #(
    parameter int CMD_W = 10,
    parameter int THR_W = 8,
    parameter int TGT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [CMD_W-1:0] cmd_value,
    input logic [THR_W-1:0] cfg_start,
    input logic [THR_W-2:0] cfg_stop,
    input logic             cfg_no_stop,
    input logic             cfg_max_off,
    input logic [TGT_W-1:0] cfg_ceiling,
    input logic             p1_valid,
    input logic [TGT_W-1:0] tgt_value,
    input logic             tgt_en,
    input logic             tgt_ovr
);

    localparam int FULL_SCALE = 1 << (CMD_W - 1);

    logic [CMD_W-1:0] start_w, stop_w;
    assign start_w = CMD_W'(cfg_start);
    assign stop_w  = CMD_W'({cfg_stop, 1'b0});

    // R3: a command above the start level is enabled two edges later
    a_r3_enable_above_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_valid, 2) && ($past(cmd_value, 2) > $past(start_w, 2))) |-> tgt_en);

    // R3: at or below stop with both low-band flags clear is disabled
    a_r3_disable_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_valid, 2) && !$past(cfg_no_stop, 2) && !$past(cfg_max_off, 2)
         && ($past(cmd_value, 2) <= $past(stop_w, 2))) |-> (!tgt_en && tgt_value == '0));

    // R7: override implies enable and a pass-through or full-scale value
    a_r7_override_value: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_valid, 2) && tgt_ovr) |->
        (tgt_en && (tgt_value == TGT_W'($past(cmd_value, 2)) || tgt_value == TGT_W'(FULL_SCALE))));

    // R12: a non-override update never exceeds the ceiling
    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(p1_valid) && !tgt_ovr) |-> (tgt_value <= $past(cfg_ceiling)));

    // R2: no pipeline update means the outputs hold
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(p1_valid) |-> ($stable(tgt_value) && $stable(tgt_en) && $stable(tgt_ovr)));

endmodule

bind speed_curve_map speed_curve_map_chk #(
    .CMD_W (CMD_W),
    .THR_W (THR_W),
    .TGT_W (TGT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_value   (cmd_value),
    .cfg_start   (cfg_start),
    .cfg_stop    (cfg_stop),
    .cfg_no_stop (cfg_no_stop),
    .cfg_max_off (cfg_max_off),
    .cfg_ceiling (cfg_ceiling),
    .p1_valid    (p1_valid),
    .tgt_value   (tgt_value),
    .tgt_en      (tgt_en),
    .tgt_ovr     (tgt_ovr)
);

// File: tb/tb_speed_curve_map.sv
`timescale 1ns/1ps
module tb_speed_curve_map;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [9:0]  cmd_value = '0;
    logic [7:0]  cfg_start = 8'd100;
    logic [6:0]  cfg_stop = 7'd40;
    logic [7:0]  cfg_clamp = 8'd143;
    logic [3:0]  cfg_ret_hys = 4'd4;
    logic [11:0] cfg_base = 12'd1000;
    logic [13:0] cfg_slope_lo = 14'd640;
    logic [13:0] cfg_slope_hi = 14'd1280;
    logic [7:0]  cfg_knee = 8'd125;
    logic [15:0] cfg_ceiling = 16'd8000;
    logic        cfg_open_loop = 1'b0;
    logic        cfg_max_open = 1'b0;
    logic        cfg_no_stop = 1'b0;
    logic        cfg_max_off = 1'b0;
    logic [15:0] tgt_value;
    logic        tgt_en;
    logic        tgt_ovr;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    speed_curve_map dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_value(cmd_value),
        .cfg_start(cfg_start), .cfg_stop(cfg_stop), .cfg_clamp(cfg_clamp),
        .cfg_ret_hys(cfg_ret_hys), .cfg_base(cfg_base), .cfg_slope_lo(cfg_slope_lo),
        .cfg_slope_hi(cfg_slope_hi), .cfg_knee(cfg_knee), .cfg_ceiling(cfg_ceiling),
        .cfg_open_loop(cfg_open_loop), .cfg_max_open(cfg_max_open),
        .cfg_no_stop(cfg_no_stop), .cfg_max_off(cfg_max_off),
        .tgt_value(tgt_value), .tgt_en(tgt_en), .tgt_ovr(tgt_ovr)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input int et, input int ee, input int eo);
        check({tag, " value"}, int'(tgt_value), et);
        check({tag, " en"}, int'(tgt_en), ee);
        check({tag, " ovr"}, int'(tgt_ovr), eo);
    endtask

    // strobe one sample, then look after the second edge
    task automatic apply(input int c, input int et, input int ee, input int eo, input string tag);
        @(negedge clk);
        cmd_value = 10'(c);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        check_out(tag, et, ee, eo);
    endtask

    // closed-loop curve sequence with the default configuration
    localparam int NV = 13;
    localparam int VC [NV] = '{ 50,  90, 101,  200,  250,  251,  400,  512,  150,   95, 80, 95, 0};
    localparam int VT [NV] = '{  0,   0,1010, 2000, 2500, 2520, 5500, 5500, 1500, 1000,  0,  0, 0};
    localparam int VE [NV] = '{  0,   0,   1,    1,    1,    1,    1,    1,    1,    1,  0,  0, 0};

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1 reset", 0, 0, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_out("R1 after release", 0, 0, 0);

        // R3 R4 R5 R6 R8 table walk
        for (int i = 0; i < NV; i++)
            apply(VC[i], VT[i], VE[i], 0, $sformatf("R4 vec%0d", i));

        // R7 direct duty and return margin
        cfg_max_open = 1'b1;
        apply(300, 3500, 1, 0, "R7 curve before");
        apply(401, 401, 1, 1, "R7 enter direct");
        apply(395, 395, 1, 1, "R7 inside margin");
        apply(390, 390, 1, 1, "R7 at return level");
        apply(389, 5280, 1, 0, "R7 return below");
        apply(50, 0, 0, 0, "R3 stop");
        apply(450, 450, 1, 1, "R7 direct from off");
        apply(60, 0, 0, 0, "R3 stop from direct");
        cfg_max_open = 1'b0;

        // R9 R10 low-band flags
        cfg_max_off = 1'b1;
        apply(0, 8000, 1, 0, "R9 maxoff zero");
        apply(50, 0, 0, 0, "R9 maxoff nonzero");
        cfg_no_stop = 1'b1;
        apply(50, 8000, 1, 0, "R9 both below stop");
        apply(90, 1000, 1, 0, "R9 both band");
        apply(0, 8000, 1, 0, "R9 both zero");
        cfg_max_open = 1'b1;
        apply(0, 512, 1, 1, "R10 full zero");
        apply(50, 512, 1, 1, "R10 full below stop");
        cfg_max_open = 1'b0;
        cfg_max_off = 1'b0;
        apply(0, 1000, 1, 0, "R9 nostop zero");
        apply(90, 1000, 1, 0, "R9 nostop band");
        cfg_no_stop = 1'b0;

        // R12 saturation
        cfg_ceiling = 16'd3000;
        apply(300, 3000, 1, 0, "R12 curve limited");
        apply(95, 1000, 1, 0, "R8 band falling");
        cfg_ceiling = 16'd900;
        apply(95, 900, 1, 0, "R12 startup limited");
        cfg_ceiling = 16'd8000;
        apply(0, 0, 0, 0, "R3 back off");

        // R5 knee disabled
        cfg_knee = 8'd0;
        apply(300, 3000, 1, 0, "R5 single slope");
        cfg_knee = 8'd125;

        // R2 hold without strobe, then latency
        @(negedge clk);
        cmd_value = 10'd450;
        cfg_ceiling = 16'd100;
        repeat (4) @(negedge clk);
        check_out("R2 no strobe", 3000, 1, 0);
        cfg_ceiling = 16'd8000;
        cmd_value = 10'd200;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 first edge", int'(tgt_value), 3000);
        @(negedge clk);
        check("R2 second edge", int'(tgt_value), 2000);

        // R11 open-loop scaling
        cfg_open_loop = 1'b1;
        cfg_base = 12'd800;
        cfg_slope_lo = 14'd3000;
        apply(0, 0, 0, 0, "R11 off");
        apply(101, 52, 1, 0, "R11 first step");
        apply(200, 342, 1, 0, "R11 floor");
        apply(300, 551, 1, 0, "R11 knee");
        apply(95, 50, 1, 0, "R11 startup duty");

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1 mid reset", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule